// File: doc/BRIEF.md
# Alarm Flag and Interrupt Controller for a Real-Time Clock

This block sits in the 32.768 kHz timekeeping domain of a real-time clock. Every clock edge is one tick. It compares the running time against two preset alarms. The weekday alarm matches on minute, hour and a mask of allowed weekdays. The daily alarm matches on minute and hour only. A match raises that alarm's status flag after a fixed two-tick delay and pulls its active-low interrupt line down. The block also holds a periodic interrupt flag, which a periodic event from the timer raises on the next tick.

The host can only lower a flag. To clear a flag it writes 0 to that flag's bit while the bit is selected; writing 1 leaves the flag as it was. A cleared alarm stays low until the next fresh match. An alarm whose enable is off reads 0, keeps its line high and loses any flag it held. The time counters, the serial host bus and the oscillator are outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: While reset is asserted, and on the first tick after it, all three status bits read 0 and all three interrupt outputs are high.
- R2: The weekday alarm compares true when curMin and curHour equal its minute and hour and bit curDay of its weekday mask is 1. The daily alarm compares true when minute and hour are equal, whatever the day.
- R3: An alarm flag first reads 1 after the second clock edge following the first edge at which its compare is sampled true. After the first edge and after the second edge it still reads 0.
- R4: A write with wrEn high clears each flag whose wrSel bit is 1 and whose wrData bit is 0. The same bit positions are used by wrSel, wrData and statusFlags: bit 0 is the periodic flag, bit 1 the weekday alarm and bit 2 the daily alarm. Unselected flags are left unchanged.
- R5: Writing 1 to a selected flag has no effect on that flag.
- R6: A flag is set on the rising edge of the compare result only. If the time stays at the alarm value after a clear, the flag stays 0. The flag sets again only after the compare falls and rises again.
- R7: Each interrupt output is low exactly while its status bit reads 1, and high otherwise.
- R8: While an alarm's enable is 0, its status bit reads 0 and its output is high, in the same cycle the enable drops. Its flag is cleared, so after the enable returns to 1 the bit stays 0 until the next match sets it.
- R9: A periodicEvt pulse sets the periodic flag on that clock edge, and the periodic output goes low with it. After a clear, the next event sets the flag again.
- R10: When a clear write and a set event for the same flag land on the same edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| curMin | input | 7 | Current minute |
| curHour | input | 6 | Current hour |
| curDay | input | 3 | Current weekday index |
| wkAlarmMin | input | 7 | Weekday alarm minute |
| wkAlarmHour | input | 6 | Weekday alarm hour |
| wkAlarmDays | input | 7 | Weekday alarm day mask, bit n enables day n |
| dyAlarmMin | input | 7 | Daily alarm minute |
| dyAlarmHour | input | 6 | Daily alarm hour |
| wkAlarmEn | input | 1 | Weekday alarm enable |
| dyAlarmEn | input | 1 | Daily alarm enable |
| periodicEvt | input | 1 | Periodic interrupt event, one tick wide |
| wrEn | input | 1 | Host write strobe for the flag bits |
| wrSel | input | 3 | Per-bit write select |
| wrData | input | 3 | Write data, only 0 has an effect |
| statusFlags | output | 3 | Flag readback: bit 0 periodic, bit 1 weekday, bit 2 daily |
| intPeriodN | output | 1 | Periodic interrupt, active low |
| intWeekN | output | 1 | Weekday alarm interrupt, active low |
| intDailyN | output | 1 | Daily alarm interrupt, active low |

## Verification
The bench counts edges after a time match. A design that set the flag too early or too late is caught at the first or third sampled tick. It holds the matching time after a clear: a level-sensitive compare would raise the flag again at once. It places a clear write on the exact edge where a delayed set lands. A design that let the clear win would read 0 there. It also drops and restores an enable around a set flag, and checks a day outside the weekday mask. Both catch a readback that leaks a stale flag or ignores the day gate.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_ALARMS = 2;
  localparam int ALARM_WK   = 0;
  localparam int ALARM_DY   = 1;
  // bit positions shared by wrSel, wrData and statusFlags
  localparam int SEL_PER    = 0;
  localparam int SEL_WK     = 1;
  localparam int SEL_DY     = 2;
  localparam int FLAG_W     = 3;

  typedef struct packed {
    logic [NUM_ALARMS-1:0] setAlarm;
    logic [NUM_ALARMS-1:0] clrAlarm;
    logic                  setPer;
    logic                  clrPer;
  } flagStrobes_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int MIN_W   = 7,
  parameter int HOUR_W  = 6,
  parameter int DAY_W   = 3,
  parameter int DAYS    = 7,
  parameter int SET_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [MIN_W-1:0]  wkMin,
  input  logic [HOUR_W-1:0] wkHour,
  input  logic [DAYS-1:0]   wkDays,
  input  logic [MIN_W-1:0]  dyMin,
  input  logic [HOUR_W-1:0] dyHour,
  input  logic              periodicEvt,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrSel,
  input  logic [FLAG_W-1:0] wrData,
  output flagStrobes_t      strobes
);
  logic [DAYS-1:0]       dayDecode;
  logic [NUM_ALARMS-1:0] hit, hitPrev, hitEdge, setDone;
  logic [FLAG_W-1:0]     clrBits;

  assign dayDecode    = DAYS'(1) << curDay;
  assign hit[ALARM_WK] = (curMin == wkMin) && (curHour == wkHour) && |(wkDays & dayDecode);
  assign hit[ALARM_DY] = (curMin == dyMin) && (curHour == dyHour);
  assign hitEdge       = hit & ~hitPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hitPrev <= '0;
    else        hitPrev <= hit;
  end

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_delay
    logic [SET_DLY-1:0] dlyPipe;
    if (SET_DLY == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dlyPipe <= '0;
        else        dlyPipe <= hitEdge[a];
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dlyPipe <= '0;
        else        dlyPipe <= {dlyPipe[SET_DLY-2:0], hitEdge[a]};
      end
    end
    assign setDone[a] = dlyPipe[SET_DLY-1];

    // R6: a match produces one set strobe, never two back to back
    assert_single_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      setDone[a] |=> !setDone[a]);
  end

  assign clrBits = {FLAG_W{wrEn}} & wrSel & ~wrData;

  always_comb begin
    strobes                    = '0;
    strobes.setAlarm           = setDone;
    strobes.clrAlarm[ALARM_WK] = clrBits[SEL_WK];
    strobes.clrAlarm[ALARM_DY] = clrBits[SEL_DY];
    strobes.setPer             = periodicEvt;
    strobes.clrPer             = clrBits[SEL_PER];
  end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  flagStrobes_t          strobes,
  input  logic [NUM_ALARMS-1:0] alarmEn,
  output logic [FLAG_W-1:0]     statusFlags,
  output logic                  intPerN,
  output logic [NUM_ALARMS-1:0] intAlarmN
);
  logic [NUM_ALARMS-1:0] alarmFlag, alarmRead;
  logic                  perFlag;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     alarmFlag[a] <= 1'b0;
      else if (!alarmEn[a])           alarmFlag[a] <= 1'b0;
      else if (strobes.setAlarm[a])   alarmFlag[a] <= 1'b1;
      else if (strobes.clrAlarm[a])   alarmFlag[a] <= 1'b0;
    end
    assign alarmRead[a] = alarmFlag[a] & alarmEn[a];
    assign intAlarmN[a] = ~alarmRead[a];

    // R10: a set strobe wins over a clear on the same edge
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes.setAlarm[a] && alarmEn[a]) |=> alarmFlag[a]);
    // R4: a clear without a set lowers the flag
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes.clrAlarm[a] && !strobes.setAlarm[a]) |=> !alarmFlag[a]);
    // R5: without a clear the flag holds while enabled
    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alarmFlag[a] && !strobes.clrAlarm[a] && alarmEn[a]) |=> alarmFlag[a]);
    // R8: a disabled alarm loses its flag
    assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !alarmEn[a] |=> !alarmFlag[a]);
    // R3: the flag rises only on a delayed set strobe
    assert_rise_needs_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarmFlag[a]) |-> $past(strobes.setAlarm[a]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              perFlag <= 1'b0;
    else if (strobes.setPer) perFlag <= 1'b1;
    else if (strobes.clrPer) perFlag <= 1'b0;
  end

  // R9: a periodic event sets the flag on that edge
  assert_per_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setPer |=> perFlag);

  always_comb begin
    statusFlags          = '0;
    statusFlags[SEL_PER] = perFlag;
    statusFlags[SEL_WK]  = alarmRead[ALARM_WK];
    statusFlags[SEL_DY]  = alarmRead[ALARM_DY];
  end
  assign intPerN = ~perFlag;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int MIN_W   = 7,
  parameter int HOUR_W  = 6,
  parameter int DAY_W   = 3,
  parameter int DAYS    = 7,
  parameter int SET_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MIN_W-1:0]  curMin,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [MIN_W-1:0]  wkAlarmMin,
  input  logic [HOUR_W-1:0] wkAlarmHour,
  input  logic [DAYS-1:0]   wkAlarmDays,
  input  logic [MIN_W-1:0]  dyAlarmMin,
  input  logic [HOUR_W-1:0] dyAlarmHour,
  input  logic              wkAlarmEn,
  input  logic              dyAlarmEn,
  input  logic              periodicEvt,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [2:0]        wrData,
  output logic [2:0]        statusFlags,
  output logic              intPeriodN,
  output logic              intWeekN,
  output logic              intDailyN
);
  flagStrobes_t          strobes;
  logic [NUM_ALARMS-1:0] alarmEn, intAlarmN;

  assign alarmEn[ALARM_WK] = wkAlarmEn;
  assign alarmEn[ALARM_DY] = dyAlarmEn;

  rtc_alarm_ctrl #(
    .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W), .DAYS(DAYS), .SET_DLY(SET_DLY)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .wkMin(wkAlarmMin), .wkHour(wkAlarmHour), .wkDays(wkAlarmDays),
    .dyMin(dyAlarmMin), .dyHour(dyAlarmHour),
    .periodicEvt(periodicEvt),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .strobes(strobes)
  );

  rtc_alarm_flags flags_i (
    .clk(clk), .rst_n(rst_n),
    .strobes(strobes), .alarmEn(alarmEn),
    .statusFlags(statusFlags), .intPerN(intPeriodN), .intAlarmN(intAlarmN)
  );

  assign intWeekN  = intAlarmN[ALARM_WK];
  assign intDailyN = intAlarmN[ALARM_DY];

  // R7: each output is low exactly while its status bit reads 1
  assert_out_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (intWeekN != statusFlags[1]) && (intDailyN != statusFlags[2]) && (intPeriodN != statusFlags[0]));
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] curMin = 7'd29, wkAlarmMin = 7'd30, dyAlarmMin = 7'd0;
  logic [5:0] curHour = 6'd7, wkAlarmHour = 6'd7, dyAlarmHour = 6'd20;
  logic [2:0] curDay = 3'd2;
  logic [6:0] wkAlarmDays = 7'b0000100;
  logic wkAlarmEn = 1'b1, dyAlarmEn = 1'b1, periodicEvt = 1'b0, wrEn = 1'b0;
  logic [2:0] wrSel = 3'b000, wrData = 3'b111;
  logic [2:0] statusFlags;
  logic intPeriodN, intWeekN, intDailyN;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rtc_alarm_irq dut_i (
    .clk(clk), .rst_n(rst_n), .curMin(curMin), .curHour(curHour), .curDay(curDay),
    .wkAlarmMin(wkAlarmMin), .wkAlarmHour(wkAlarmHour), .wkAlarmDays(wkAlarmDays),
    .dyAlarmMin(dyAlarmMin), .dyAlarmHour(dyAlarmHour),
    .wkAlarmEn(wkAlarmEn), .dyAlarmEn(dyAlarmEn), .periodicEvt(periodicEvt),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .statusFlags(statusFlags), .intPeriodN(intPeriodN),
    .intWeekN(intWeekN), .intDailyN(intDailyN)
  );

  // behavioural reference: scheduled set times per alarm
  int  cyc = 0;
  int  schedW[$];
  int  schedD[$];
  bit  prevW = 0, prevD = 0;
  bit  mW = 0, mD = 0, mP = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; schedW.delete(); schedD.delete();
      prevW = 0; prevD = 0; mW = 0; mD = 0; mP = 0;
    end else begin
      bit hw, hd, sw, sd, cw, cd, cp;
      cyc++;
      hw = (curMin == wkAlarmMin) && (curHour == wkAlarmHour) && (curDay < 7) && wkAlarmDays[curDay];
      hd = (curMin == dyAlarmMin) && (curHour == dyAlarmHour);
      sw = 0; sd = 0;
      if (schedW.size() > 0 && schedW[0] == cyc) begin sw = 1; void'(schedW.pop_front()); end
      if (schedD.size() > 0 && schedD[0] == cyc) begin sd = 1; void'(schedD.pop_front()); end
      if (hw && !prevW) schedW.push_back(cyc + 2);
      if (hd && !prevD) schedD.push_back(cyc + 2);
      prevW = hw; prevD = hd;
      cw = wrEn && wrSel[1] && !wrData[1];
      cd = wrEn && wrSel[2] && !wrData[2];
      cp = wrEn && wrSel[0] && !wrData[0];
      mW = wkAlarmEn ? (sw ? 1'b1 : (cw ? 1'b0 : mW)) : 1'b0;
      mD = dyAlarmEn ? (sd ? 1'b1 : (cd ? 1'b0 : mD)) : 1'b0;
      mP = periodicEvt ? 1'b1 : (cp ? 1'b0 : mP);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] expS;
      expS = {mD & dyAlarmEn, mW & wkAlarmEn, mP};
      checks++;
      if (statusFlags !== expS || {intDailyN, intWeekN, intPeriodN} !== ~expS) begin
        errors++;
        $display("FAIL R7 model t=%0t: status=%b outs=%b exp status=%b", $time,
                 statusFlags, {intDailyN, intWeekN, intPeriodN}, expS);
      end
    end
  end

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic hostWrite(logic [2:0] sel, logic [2:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0; wrSel = 3'b000; wrData = 3'b111;
  endtask

  // {status bit, output} helpers
  function automatic logic [3:0] wk();  return {2'b00, statusFlags[1], intWeekN};   endfunction
  function automatic logic [3:0] dy();  return {2'b00, statusFlags[2], intDailyN};  endfunction
  function automatic logic [3:0] per(); return {2'b00, statusFlags[0], intPeriodN}; endfunction

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 during reset", {statusFlags, intPeriodN & intWeekN & intDailyN}, 4'b0001);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", {statusFlags, intPeriodN & intWeekN & intDailyN}, 4'b0001);

    // R2 R3: weekday alarm matches at 07:30 on day 2
    curMin = 7'd30;
    tick(); chk("R3 edge 1", wk(), 4'b0001);
    tick(); chk("R3 edge 2", wk(), 4'b0001);
    tick(); chk("R3 edge 3 set, R7 low", wk(), 4'b0010);

    // R5: writing one has no effect
    hostWrite(3'b010, 3'b111);
    chk("R5 write one keeps weekday flag", wk(), 4'b0010);
    // R4: unselected bit with zero data untouched
    hostWrite(3'b001, 3'b000);
    chk("R4 unselected flag kept", wk(), 4'b0010);
    // R4: clear by zero
    hostWrite(3'b010, 3'b000);
    chk("R4 clear weekday, R7 high", wk(), 4'b0001);
    // R6: time still matching, no re-set
    tick(5);
    chk("R6 no re-set while time held", wk(), 4'b0001);
    // R6: next match sets again
    curMin = 7'd31; tick();
    curMin = 7'd30; tick(2);
    chk("R6 not yet set", wk(), 4'b0001);
    tick();
    chk("R6 re-asserted at next match", wk(), 4'b0010);

    // R10: clear write landing on the set edge
    hostWrite(3'b010, 3'b000);
    curMin = 7'd31; tick();
    curMin = 7'd30; tick(2);
    wrEn = 1'b1; wrSel = 3'b010; wrData = 3'b000;
    tick();
    wrEn = 1'b0; wrSel = 3'b000; wrData = 3'b111;
    chk("R10 set wins over clear", wk(), 4'b0010);
    hostWrite(3'b010, 3'b000);

    // R2: day outside the mask does not match
    curMin = 7'd31; tick();
    curDay = 3'd3; curMin = 7'd30; tick(4);
    chk("R2 day outside mask", wk(), 4'b0001);
    curDay = 3'd2; tick(3);
    chk("R2 day inside mask", wk(), 4'b0010);
    hostWrite(3'b010, 3'b000);

    // R2: daily alarm ignores the day
    curDay = 3'd5; curHour = 6'd20; curMin = 7'd0;
    tick(2); chk("R3 daily not early", dy(), 4'b0001);
    tick();  chk("R2 daily set on any day", dy(), 4'b0010);

    // R8: disabling hides and clears the flag
    dyAlarmEn = 1'b0; #1;
    chk("R8 disabled reads zero", dy(), 4'b0001);
    tick(2);
    dyAlarmEn = 1'b1; tick();
    chk("R8 flag gone after re-enable", dy(), 4'b0001);

    // R9: periodic flag
    periodicEvt = 1'b1; tick(); periodicEvt = 1'b0;
    chk("R9 periodic set", per(), 4'b0010);
    hostWrite(3'b001, 3'b111);
    chk("R5 periodic write one ignored", per(), 4'b0010);
    hostWrite(3'b001, 3'b110);
    chk("R4 periodic cleared", per(), 4'b0001);
    tick(3);
    chk("R9 stays clear until next event", per(), 4'b0001);
    periodicEvt = 1'b1; wrEn = 1'b1; wrSel = 3'b001; wrData = 3'b000;
    tick();
    periodicEvt = 1'b0; wrEn = 1'b0; wrSel = 3'b000; wrData = 3'b111;
    chk("R10 periodic set wins", per(), 4'b0010);

    tick(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule